// File: doc/BRIEF.md
# Sized Add/Subtract Unit with Condition Codes

This block is the integer add and subtract datapath of a processor execution stage. It takes a destination operand and a source operand, works on the byte, word or long slice selected by a size code, and returns the sized result together with the next values of five condition flags: extend, negative, zero, overflow and carry. The sum or difference and all of the flags are computed combinationally in the same cycle.

Six operations are supported. Plain add and subtract use the source operand. The extend forms also add the incoming extend bit, or subtract it as a borrow, so that wide values can be processed in chained pieces. The quick forms replace the source operand with a small literal from 1 to 8. If the caller marks the destination as an address register, the result is still produced but the flags pass through unchanged. Operand decoding, fetch and write-back are done by the surrounding pipeline.

Top module: `addsub_ccr`

## Requirements
- R1: `op_i` selects the operation: 000 add, 001 add-with-extend, 010 quick add, 100 subtract, 101 subtract-with-extend, 110 quick subtract. Codes 011 and 111 act as plain add and plain subtract. Add computes destination plus source and subtract computes destination minus source, both within the sized slice.
- R2: `size_i` encoding is 00 byte (bits 7:0), 01 word (bits 15:0), 10 long (bits 31:0), and 11 acts as long. Result bits above the selected size are copied from `dst_i`.
- R3: N is the most significant bit of the sized result.
- R4: Z is 1 exactly when the sized result is all zeros.
- R5: V is 1 exactly when the sized signed two's-complement result overflows.
- R6: For add, C is the carry out of the sized MSB. For subtract, C is the borrow: the unsigned source, plus the extend bit in the extend forms, exceeds the unsigned destination. X is always written with the same value as C.
- R7: The extend forms use the incoming X bit (`ccr_i[4]`) as a carry-in for add and as a borrow-in for subtract. The other forms ignore it.
- R8: The quick forms use the 3-bit literal `qimm_i` in place of the source, with code 0 meaning 8 and codes 1 to 7 meaning themselves. `src_i` is ignored in these forms.
- R9: When `dst_is_addr_i` is 1, `ccr_o` equals `ccr_i`, and `res_o` is still the computed result.
- R10: The flag vectors are ordered X, N, Z, V, C in bits 4 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | DATA_W (32) | Destination operand |
| src_i | input | DATA_W (32) | Source operand |
| qimm_i | input | 3 | Quick literal code (0 means 8) |
| size_i | input | 2 | Operand size select |
| op_i | input | 3 | Operation select |
| ccr_i | input | 5 | Current flags {X,N,Z,V,C} |
| dst_is_addr_i | input | 1 | Destination is an address register, so the flags are held |
| res_o | output | DATA_W (32) | Result, with destination bits kept above the size |
| ccr_o | output | 5 | Next flags {X,N,Z,V,C} |

## Verification
The bound checker evaluates its assertions whenever the ports change. They check that the flags are held for address-register destinations, that X matches C, that N and Z agree with the sized result, that the bits above the size are passed through, and that overflow only occurs when the operand signs allow it. Exact sums and differences, borrow polarity, the use of the incoming extend bit, and the mapping of quick literal code 0 to 8 can only be confirmed by the bench. The bench compares the outputs with a reference model written separately in 64-bit integer arithmetic, using directed wrap-around cases and seeded random operands.

// File: rtl/addsub_ccr_pkg.sv
package addsub_ccr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_ALT  = 2'b11
  } size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  typedef struct packed {
    logic sub;
    logic ext;
    logic quick;
  } op_ctl_t;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/asc_op_decode.sv
module asc_op_decode
  import addsub_ccr_pkg::*;
(
  input  logic [2:0] op_i,
  output op_ctl_t    ctl_o
);

  always_comb begin
    ctl_o       = '0;
    ctl_o.sub   = op_i[2];
    ctl_o.ext   = (op_i[1:0] == 2'b01);
    ctl_o.quick = (op_i[1:0] == 2'b10);
  end

endmodule

// File: rtl/asc_src_sel.sv
module asc_src_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [2:0]        qimm_i,
  input  logic              quick_i,
  output logic [DATA_W-1:0] src_o
);

  logic [3:0] lit;

  always_comb begin
    lit = (qimm_i == 3'd0) ? 4'd8 : {1'b0, qimm_i};
    if (quick_i) begin
      src_o = {{(DATA_W-4){1'b0}}, lit};
    end else begin
      src_o = src_i;
    end
  end

endmodule

// File: rtl/asc_lane.sv
module asc_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         xin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic         ci;
  logic [W:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    ci      = sub_i ? ~xin_i : xin_i;
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci};
    sum_o   = wide[W-1:0];
    carry_o = sub_i ? ~wide[W] : wide[W];
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
  end

endmodule

// File: rtl/addsub_ccr.sv
module addsub_ccr
  import addsub_ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [2:0]        qimm_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        op_i,
  input  logic [4:0]        ccr_i,
  input  logic              dst_is_addr_i,
  output logic [DATA_W-1:0] res_o,
  output logic [4:0]        ccr_o
);

  localparam int LONG_W = DATA_W;
  localparam int WORD_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  op_ctl_t           ctl;
  logic [DATA_W-1:0] src_eff;
  logic              xin;
  ccr_t              cur;

  logic [DATA_W-1:0] lane_sum [NUM_LANES];
  logic              lane_c   [NUM_LANES];
  logic              lane_v   [NUM_LANES];

  assign cur = ccr_t'(ccr_i);
  assign xin = ctl.ext & cur.x;

  asc_op_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  asc_src_sel #(.DATA_W(DATA_W)) u_src (
    .src_i   (src_i),
    .qimm_i  (qimm_i),
    .quick_i (ctl.quick),
    .src_o   (src_eff)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = BYTE_W << g;
    logic [LW-1:0] s;
    asc_lane #(.W(LW)) u_lane (
      .a_i     (dst_i[LW-1:0]),
      .b_i     (src_eff[LW-1:0]),
      .sub_i   (ctl.sub),
      .xin_i   (xin),
      .sum_o   (s),
      .carry_o (lane_c[g]),
      .ovf_o   (lane_v[g])
    );
    if (LW < DATA_W) begin : g_pad
      assign lane_sum[g] = {dst_i[DATA_W-1:LW], s};
    end else begin : g_full
      assign lane_sum[g] = s;
    end
  end

  size_e             sz;
  logic [1:0]        sel;
  logic              msb;
  logic              zero;
  ccr_t              nxt;

  always_comb begin
    sz  = size_e'(size_i);
    unique case (sz)
      SZ_BYTE: sel = 2'd0;
      SZ_WORD: sel = 2'd1;
      default: sel = 2'd2;
    endcase
    res_o = lane_sum[sel];
    unique case (sel)
      2'd0:    begin msb = res_o[BYTE_W-1]; zero = (res_o[BYTE_W-1:0] == '0); end
      2'd1:    begin msb = res_o[WORD_W-1]; zero = (res_o[WORD_W-1:0] == '0); end
      default: begin msb = res_o[LONG_W-1]; zero = (res_o == '0); end
    endcase
    nxt.c = lane_c[sel];
    nxt.x = lane_c[sel];
    nxt.v = lane_v[sel];
    nxt.n = msb;
    nxt.z = zero;
    ccr_o = dst_is_addr_i ? ccr_i : nxt;
  end

endmodule

// File: rtl/addsub_ccr_checker.sv
module addsub_ccr_checker #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [2:0]        qimm_i,
  input logic [1:0]        size_i,
  input logic [2:0]        op_i,
  input logic [4:0]        ccr_i,
  input logic              dst_is_addr_i,
  input logic [DATA_W-1:0] res_o,
  input logic [4:0]        ccr_o
);

  int                w;
  logic [DATA_W-1:0] hi_mask;
  logic [DATA_W-1:0] lo_mask;
  logic              r_msb, d_msb, s_msb;

  always_comb begin
    w       = (size_i == 2'b00) ? DATA_W / 4 : (size_i == 2'b01) ? DATA_W / 2 : DATA_W;
    lo_mask = (w == DATA_W) ? '1 : ((DATA_W'(1) << w) - DATA_W'(1));
    hi_mask = ~lo_mask;
    r_msb   = res_o[w-1];
    d_msb   = dst_i[w-1];
    s_msb   = src_i[w-1];

    p_addr_hold_r9: assert (!dst_is_addr_i || ccr_o == ccr_i)
      else $error("flags changed for address destination");
    p_x_eq_c_r6: assert (dst_is_addr_i || ccr_o[4] == ccr_o[0])
      else $error("X differs from C");
    p_n_msb_r3: assert (dst_is_addr_i || ccr_o[3] == r_msb)
      else $error("N disagrees with sized result");
    p_z_zero_r4: assert (dst_is_addr_i || ccr_o[2] == ((res_o & lo_mask) == '0))
      else $error("Z disagrees with sized result");
    p_upper_pass_r2: assert ((res_o & hi_mask) == (dst_i & hi_mask))
      else $error("upper bits not passed through");
    p_v_signs_r5: assert (dst_is_addr_i || op_i[1:0] == 2'b10 || !ccr_o[1] ||
                          (op_i[2] ? (d_msb != s_msb) : (d_msb == s_msb)))
      else $error("overflow with incompatible operand signs");
  end

endmodule

bind addsub_ccr addsub_ccr_checker #(.DATA_W(DATA_W)) u_addsub_ccr_checker (.*);

// File: tb/test_addsub_ccr.sv
module test_addsub_ccr;

  logic        clk;
  logic        rst_n;
  logic [31:0] dst, src, res;
  logic [2:0]  qimm, op;
  logic [1:0]  size;
  logic [4:0]  ccr_in, ccr_out;
  logic        adr;
  int          total;
  int          bad;
  bit          done;

  addsub_ccr i_addsub_ccr (
    .dst_i         (dst),
    .src_i         (src),
    .qimm_i        (qimm),
    .size_i        (size),
    .op_i          (op),
    .ccr_i         (ccr_in),
    .dst_is_addr_i (adr),
    .res_o         (res),
    .ccr_o         (ccr_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model in 64-bit integer arithmetic; returns {res, ccr}.
  function automatic logic [36:0] model(input logic [31:0] d32, input logic [31:0] s32,
                                        input logic [2:0] q, input logic [1:0] sz,
                                        input logic [2:0] o, input logic [4:0] ci,
                                        input logic ad);
    longint wd, mask, half, d, s, cin, r, sd, ss, sr, rm;
    logic   c, v, n, z;
    logic [31:0] rr;
    wd   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (longint'(1) << wd) - 1;
    half = longint'(1) << (wd - 1);
    d    = longint'(d32) & mask;
    if (o[1:0] == 2'b10) s = (q == 3'd0) ? 8 : longint'(q);
    else                 s = longint'(s32) & mask;
    cin  = (o[1:0] == 2'b01) ? longint'(ci[4]) : 0;
    if (o[2]) begin r = d - s - cin; c = (r < 0); end
    else      begin r = d + s + cin; c = (r > mask); end
    sd = (d >= half) ? d - (mask + 1) : d;
    ss = (s >= half) ? s - (mask + 1) : s;
    sr = o[2] ? (sd - ss - cin) : (sd + ss + cin);
    v  = (sr < -half) || (sr >= half);
    rm = r & mask;
    n  = (rm >= half);
    z  = (rm == 0);
    rr = (d32 & ~32'(mask)) | 32'(rm);
    return {rr, ad ? ci : {c, n, z, v, c}};
  endfunction

  task automatic apply(input logic [31:0] d, input logic [31:0] s, input logic [2:0] q,
                       input logic [1:0] sz, input logic [2:0] o, input logic [4:0] ci,
                       input logic ad);
    @(posedge clk);
    #1;
    dst = d; src = s; qimm = q; size = sz; op = o; ccr_in = ci; adr = ad;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [31:0] er, input logic [4:0] ec);
    total++;
    if (res !== er || ccr_out !== ec) begin
      bad++;
      $display("FAIL %s: res=%h ccr=%b expected res=%h ccr=%b", tag, res, ccr_out, er, ec);
    end
  endtask

  initial begin
    int cycles;
    cycles = 0;
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [36:0] m;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    dst = '0; src = '0; qimm = '0; size = 2'b10; op = 3'b000; ccr_in = '0; adr = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state with all-zero inputs: 0+0 long gives Z only (R4, R10)
    expect_out("R4 idle", 32'h0, 5'b00100);

    apply(32'hAABBCC7F, 32'h1, 0, 2'b00, 3'b000, 5'b0, 0);
    expect_out("R5 byte overflow, R2 upper kept", 32'hAABBCC80, 5'b01010);
    apply(32'h000000FF, 32'h1, 0, 2'b00, 3'b000, 5'b0, 0);
    expect_out("R6 byte carry", 32'h0, 5'b10101);
    apply(32'h0, 32'h1, 0, 2'b00, 3'b100, 5'b0, 0);
    expect_out("R6 byte borrow", 32'h000000FF, 5'b11001);
    apply(32'h12348000, 32'h1, 0, 2'b01, 3'b100, 5'b0, 0);
    expect_out("R5 word sub overflow", 32'h12347FFF, 5'b00010);
    apply(32'hFFFFFFFF, 32'h0, 0, 2'b10, 3'b001, 5'b10000, 0);
    expect_out("R7 add-extend carry in", 32'h0, 5'b10101);
    apply(32'h05, 32'h05, 0, 2'b00, 3'b101, 5'b10000, 0);
    expect_out("R7 sub-extend borrow in", 32'h000000FF, 5'b11001);
    apply(32'h10, 32'hDEADBEEF, 3'd0, 2'b10, 3'b010, 5'b0, 0);
    expect_out("R8 quick code 0 is 8", 32'h18, 5'b00000);
    apply(32'h00000002, 32'hFFFFFFFF, 3'd3, 2'b01, 3'b110, 5'b0, 0);
    expect_out("R8 quick sub word", 32'h0000FFFF, 5'b11001);
    apply(32'hFFFFFFFF, 32'h1, 0, 2'b10, 3'b000, 5'b01010, 1);
    expect_out("R9 address destination holds flags", 32'h0, 5'b01010);
    apply(32'h7FFFFFFF, 32'h1, 0, 2'b11, 3'b000, 5'b0, 0);
    expect_out("R2 size 11 as long", 32'h80000000, 5'b01010);
    apply(32'h10, 32'h20, 0, 2'b00, 3'b011, 5'b10000, 0);
    expect_out("R1 code 011 plain add ignores X", 32'h30, 5'b00000);
    apply(32'h00007000, 32'h1000, 0, 2'b01, 3'b000, 5'b0, 0);
    expect_out("R3 word negative", 32'h00008000, 5'b01010);
    apply(32'h30, 32'h30, 0, 2'b00, 3'b111, 5'b10000, 0);
    expect_out("R1 code 111 plain sub", 32'h0, 5'b00100);

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      apply($urandom, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 3)) : $urandom,
            3'($urandom), 2'($urandom), o, 5'($urandom), ($urandom_range(0, 7) == 0));
      m = model(dst, src, qimm, size, op, ccr_in, adr);
      expect_out("R1 random vs model", m[36:5], m[4:0]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule